// File: doc/BRIEF.md
# Keyed-Reload Watchdog Timer

This peripheral guards a system against software that has stopped making progress. Software programs a time-out constant and arms the timer with a deferred mode write. The timer then counts down once per pulse of a slow watchdog tick input. Software keeps it alive by writing a two-byte key to the feed register: first 0xAA, then 0x55, with no other register access between them. A correct key reloads the down-counter from the constant. If software stops feeding, the counter underflows. The block then records a time-out and does one of two things: it raises a level interrupt, or it issues a one-cycle chip-reset request.

All register access goes through a generic single-cycle bus. The select, write-enable, address and write data are sampled on the rising clock edge. Read data is combinational from the current state. A write to the mode register does not act at once on the enable and reset-enable bits. It is held pending until the next valid feed completes. Once set, those two bits cannot be cleared by software.

Two synchronous resets are provided. `rst_por` is the power-on or brown-out reset and clears everything. `rst_sys` is the ordinary system reset, typically driven by the chip-reset request. It clears everything except the time-out flag, so software can tell after a reset that the watchdog caused it.

Top module: `feedwd_top`

## Requirements
- R1: After `rst_por`, the mode register reads 0, the time-out constant reads 0xFF, the current value reads 0xFF, and `irq_o` and `rst_req_o` are low.
- R2: Register byte offsets are 0x0 mode, 0x4 time-out constant, 0x8 feed and 0xC current value. The feed register reads 0. Writes to the current-value register are ignored. Mode bits are: bit 0 enable, bit 1 reset-enable, bit 2 time-out flag, bit 3 interrupt flag. Bits 31:4 read 0.
- R3: Enable and reset-enable are set-only. Writing 0 to them never clears them. Only a reset or an underflow clears them.
- R4: A feed-register write of 0xAA (low byte) followed, as the very next bus access, by a feed-register write of 0x55 reloads the counter from the time-out constant. The reload takes effect on the clock edge of the 0x55 write.
- R5: The feed is aborted and nothing is reloaded in either of two cases: the access after the 0xAA write is any other access (read or write, any address), or the second byte is not 0x55.
- R6: A mode write ORs its bits 0 and 1 into a pending set. The pending bits reach enable and reset-enable only when the next valid feed completes.
- R7: While enable is set, the counter decrements by one on each cycle with `wdt_tick` high. While enable is clear, the counter holds.
- R8: A tick while the count is 0 is a time-out. A time-out sets the time-out flag and clears enable and reset-enable. If reset-enable was set, `rst_req_o` is high for exactly one cycle. Otherwise the interrupt flag is set and `irq_o` follows it. A valid feed in the same cycle takes precedence over the time-out.
- R9: A mode write with bit 2 = 0 clears the time-out flag at once. Writing 1 to bit 2 has no effect. The interrupt flag cannot be cleared by software.
- R10: `rst_sys` clears all state except the time-out flag. `rst_por` clears all state, including the time-out flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst_por | input | 1 | Synchronous power-on reset, clears all state |
| rst_sys | input | 1 | Synchronous system reset, keeps the time-out flag |
| wdt_tick | input | 1 | Watchdog count enable, one pulse per timer step |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational |
| irq_o | output | 1 | Time-out interrupt level |
| rst_req_o | output | 1 | One-cycle chip-reset request |

## Verification
Register writes and feeds take effect on the edge that samples them. Because read data is combinational, each result is read back in the first access after that edge. The bench drives every input on the falling edge and samples `bus_rdata` one nanosecond later, while the read is still on the bus. Tick-driven results follow the same rule: after N tick cycles, counted edge by edge from the feed, the expected count is the constant minus N. A time-out lands on the edge of the tick that finds the count at 0, and `rst_req_o` is checked high on that same half-cycle and low one cycle later. Ticks are held low during reads, so every read sees a settled count.

// File: rtl/feedwd_pkg.sv
package feedwd_pkg;

    localparam int unsigned REG_ADDR_W = 4;

    localparam logic [REG_ADDR_W-1:0] OFS_MODE = 4'h0;
    localparam logic [REG_ADDR_W-1:0] OFS_TC   = 4'h4;
    localparam logic [REG_ADDR_W-1:0] OFS_FEED = 4'h8;
    localparam logic [REG_ADDR_W-1:0] OFS_VAL  = 4'hC;

    localparam logic [7:0] KEY_FIRST  = 8'hAA;
    localparam logic [7:0] KEY_SECOND = 8'h55;

    localparam int unsigned MODE_W = 4;

    typedef enum logic [2:0] {
        RS_NONE,
        RS_MODE,
        RS_TC,
        RS_FEED,
        RS_VAL
    } reg_sel_t;

    typedef enum logic {
        FS_IDLE,
        FS_KEYED
    } feed_state_t;

    // bit 3 .. bit 0 of the mode register
    typedef struct packed {
        logic intf;
        logic tof;
        logic rsten;
        logic en;
    } mode_t;

    function automatic reg_sel_t decode_reg(input logic [REG_ADDR_W-1:0] a);
        reg_sel_t r;
        case (a)
            OFS_MODE: r = RS_MODE;
            OFS_TC:   r = RS_TC;
            OFS_FEED: r = RS_FEED;
            OFS_VAL:  r = RS_VAL;
            default:  r = RS_NONE;
        endcase
        return r;
    endfunction

    function automatic logic key_match(input logic [7:0] b, input logic [7:0] k);
        return b == k;
    endfunction

endpackage

// File: rtl/feedwd_regif.sv
module feedwd_regif
    import feedwd_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 4
) (
    input  logic              sel,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  mode_t             mode,
    input  logic [CNT_W-1:0]  tc,
    input  logic [CNT_W-1:0]  cnt,
    output logic              wr_mode,
    output logic              wr_tc,
    output logic              wr_feed,
    output logic              access,
    output logic [DATA_W-1:0] rdata
);

    reg_sel_t rs;

    always_comb begin
        rs = decode_reg(REG_ADDR_W'(addr));
        if (ADDR_W > REG_ADDR_W) begin
            if ((addr >> REG_ADDR_W) != '0) rs = RS_NONE;
        end
    end

    assign access  = sel;
    assign wr_mode = sel && we && (rs == RS_MODE);
    assign wr_tc   = sel && we && (rs == RS_TC);
    assign wr_feed = sel && we && (rs == RS_FEED);

    always_comb begin
        rdata = '0;
        case (rs)
            RS_MODE: rdata[MODE_W-1:0] = mode;
            RS_TC:   rdata = DATA_W'(tc);
            RS_VAL:  rdata = DATA_W'(cnt);
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/feedwd_feed.sv
module feedwd_feed
    import feedwd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       access,
    input  logic       wr_feed,
    input  logic [7:0] key,
    output logic       feed_ok
);

    feed_state_t st_q, st_d;

    always_comb begin
        st_d    = st_q;
        feed_ok = 1'b0;
        if (access) begin
            if (wr_feed && key_match(key, KEY_FIRST)) begin
                st_d = FS_KEYED;
            end else begin
                st_d = FS_IDLE;
                if (st_q == FS_KEYED && wr_feed && key_match(key, KEY_SECOND))
                    feed_ok = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= FS_IDLE;
        else     st_q <= st_d;
    end

endmodule

// File: rtl/feedwd_mode.sv
module feedwd_mode
    import feedwd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_por,
    input  logic       rst_sys,
    input  logic       wr_mode,
    input  logic [2:0] wbits,
    input  logic       feed_ok,
    input  logic       expire,
    output mode_t      mode_q
);

    logic pend_en_q;
    logic pend_rst_q;

    always_ff @(posedge clk) begin
        if (rst_por || rst_sys) begin
            mode_q.en    <= 1'b0;
            mode_q.rsten <= 1'b0;
            mode_q.intf  <= 1'b0;
            pend_en_q    <= 1'b0;
            pend_rst_q   <= 1'b0;
            if (rst_por) mode_q.tof <= 1'b0;
        end else begin
            if (wr_mode) begin
                pend_en_q  <= pend_en_q  | wbits[0];
                pend_rst_q <= pend_rst_q | wbits[1];
                if (!wbits[2]) mode_q.tof <= 1'b0;
            end
            if (feed_ok) begin
                mode_q.en    <= mode_q.en    | pend_en_q;
                mode_q.rsten <= mode_q.rsten | pend_rst_q;
                pend_en_q    <= 1'b0;
                pend_rst_q   <= 1'b0;
            end
            if (expire) begin
                mode_q.en    <= 1'b0;
                mode_q.rsten <= 1'b0;
                mode_q.tof   <= 1'b1;
                if (!mode_q.rsten) mode_q.intf <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/feedwd_count.sv
module feedwd_count #(
    parameter int              CNT_W    = 32,
    parameter logic [CNT_W-1:0] TC_RESET = CNT_W'(8'hFF)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             run,
    input  logic             feed_ok,
    input  logic             wr_tc,
    input  logic [CNT_W-1:0] tc_wdata,
    output logic [CNT_W-1:0] tc_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             expire
);

    logic at_zero;
    logic step;

    assign at_zero = (cnt_q == '0);
    assign step    = run && tick;
    assign expire  = step && at_zero && !feed_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            tc_q  <= TC_RESET;
            cnt_q <= TC_RESET;
        end else begin
            if (wr_tc) tc_q <= tc_wdata;
            if (feed_ok)
                cnt_q <= tc_q;
            else if (step && !at_zero)
                cnt_q <= cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/feedwd_top.sv
module feedwd_top
    import feedwd_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_por,
    input  logic              rst_sys,
    input  logic              wdt_tick,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o,
    output logic              rst_req_o
);

    localparam logic [CNT_W-1:0] TC_INIT = CNT_W'(8'hFF);

    logic             rst_any;
    logic             wr_mode, wr_tc, wr_feed, access;
    logic             feed_ok, expire;
    mode_t            mode_q;
    logic [CNT_W-1:0] tc_q, cnt_q;
    logic             rst_req_q;

    assign rst_any = rst_por | rst_sys;

    feedwd_regif #(.DATA_W(DATA_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regif (
        .sel     (bus_sel),
        .we      (bus_we),
        .addr    (bus_addr),
        .mode    (mode_q),
        .tc      (tc_q),
        .cnt     (cnt_q),
        .wr_mode (wr_mode),
        .wr_tc   (wr_tc),
        .wr_feed (wr_feed),
        .access  (access),
        .rdata   (bus_rdata)
    );

    feedwd_feed u_feed (
        .clk     (clk),
        .rst     (rst_any),
        .access  (access),
        .wr_feed (wr_feed),
        .key     (bus_wdata[7:0]),
        .feed_ok (feed_ok)
    );

    feedwd_mode u_mode (
        .clk     (clk),
        .rst_por (rst_por),
        .rst_sys (rst_sys),
        .wr_mode (wr_mode),
        .wbits   (bus_wdata[2:0]),
        .feed_ok (feed_ok),
        .expire  (expire),
        .mode_q  (mode_q)
    );

    feedwd_count #(.CNT_W(CNT_W), .TC_RESET(TC_INIT)) u_count (
        .clk      (clk),
        .rst      (rst_any),
        .tick     (wdt_tick),
        .run      (mode_q.en),
        .feed_ok  (feed_ok),
        .wr_tc    (wr_tc),
        .tc_wdata (bus_wdata[CNT_W-1:0]),
        .tc_q     (tc_q),
        .cnt_q    (cnt_q),
        .expire   (expire)
    );

    always_ff @(posedge clk) begin
        if (rst_any) rst_req_q <= 1'b0;
        else         rst_req_q <= expire && mode_q.rsten;
    end

    assign rst_req_o = rst_req_q;
    assign irq_o     = mode_q.intf;

endmodule

// File: rtl/feedwd_chk.sv
module feedwd_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_por,
    input logic             rst_sys,
    input logic             tick,
    input logic             feed_ok,
    input logic             expire,
    input logic [3:0]       mode_bits,
    input logic [CNT_W-1:0] tc_q,
    input logic [CNT_W-1:0] cnt_q,
    input logic             rst_req_o,
    input logic             irq_o
);

    logic rst_any;
    assign rst_any = rst_por | rst_sys;

    p_rst_req_single_r8: assert property (@(posedge clk) disable iff (rst_any)
        rst_req_o |=> !rst_req_o);

    p_rst_req_cause_r8: assert property (@(posedge clk) disable iff (rst_any)
        (!$past(rst_any) && rst_req_o) |-> $past(expire && mode_bits[1]));

    p_irq_cause_r8: assert property (@(posedge clk) disable iff (rst_any)
        (!$past(rst_any) && $rose(irq_o)) |-> $past(expire && !mode_bits[1]));

    p_en_sticky_r3: assert property (@(posedge clk) disable iff (rst_any)
        (!$past(rst_any) && $past(mode_bits[0]) && !$past(expire)) |-> mode_bits[0]);

    p_reload_r4: assert property (@(posedge clk) disable iff (rst_any)
        feed_ok |=> (cnt_q == $past(tc_q)));

    p_count_hold_r7: assert property (@(posedge clk) disable iff (rst_any)
        (!$past(rst_any) && !$past(feed_ok) && !($past(mode_bits[0]) && $past(tick)))
            |-> $stable(cnt_q));

    p_intf_sticky_r9: assert property (@(posedge clk) disable iff (rst_any)
        (!$past(rst_any) && $past(mode_bits[3])) |-> mode_bits[3]);

endmodule

bind feedwd_top feedwd_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_por   (rst_por),
    .rst_sys   (rst_sys),
    .tick      (wdt_tick),
    .feed_ok   (feed_ok),
    .expire    (expire),
    .mode_bits (mode_q),
    .tc_q      (tc_q),
    .cnt_q     (cnt_q),
    .rst_req_o (rst_req_o),
    .irq_o     (irq_o)
);

// File: tb/sim_feedwd_top.sv
`timescale 1ns/1ps
module sim_feedwd_top;

    logic        clk = 1'b0;
    logic        rst_por = 1'b1;
    logic        rst_sys = 1'b0;
    logic        tick = 1'b0;
    logic        sel = 1'b0;
    logic        we = 1'b0;
    logic [3:0]  addr = 4'h0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    logic        rreq;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    feedwd_top u0 (
        .clk       (clk),
        .rst_por   (rst_por),
        .rst_sys   (rst_sys),
        .wdt_tick  (tick),
        .bus_sel   (sel),
        .bus_we    (we),
        .bus_addr  (addr),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .irq_o     (irq),
        .rst_req_o (rreq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        sel = 1'b1; we = 1'b1; addr = a; wdata = d;
        cyc();
        sel = 1'b0; we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        sel = 1'b1; we = 1'b0; addr = a;
        #1 d = rdata;
        cyc();
        sel = 1'b0;
    endtask

    task automatic feed();
        wr(4'h8, 32'hAA);
        wr(4'h8, 32'h55);
    endtask

    task automatic ticks(input int n);
        tick = 1'b1;
        repeat (n) cyc();
        tick = 1'b0;
    endtask

    task automatic pulse_por();
        rst_por = 1'b1; cyc(); rst_por = 1'b0;
    endtask

    function automatic logic [31:0] exp_count(input logic [31:0] tcv, input int n);
        return tcv - 32'(n);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] tcv;
        int nt;
        void'($urandom(32'h5EED_1234));
        @(negedge clk); cyc();
        rst_por = 1'b0;

        // R1 reset state
        rd(4'h0, v); check("R1 mode", v, 32'h0);
        rd(4'h4, v); check("R1 tc", v, 32'hFF);
        rd(4'hC, v); check("R1 value", v, 32'hFF);
        check("R1 irq", {31'b0, irq}, 0);
        check("R1 rst_req", {31'b0, rreq}, 0);

        // R2 map
        rd(4'h8, v); check("R2 feed reads 0", v, 0);
        wr(4'hC, 32'h1234); rd(4'hC, v); check("R2 value write ignored", v, 32'hFF);
        wr(4'h4, 32'd10); rd(4'h4, v); check("R2 tc readback", v, 32'd10);

        // R6 deferred enable, R7 no count while disabled
        wr(4'h0, 32'h1); rd(4'h0, v); check("R6 enable pending", v, 0);
        ticks(3); rd(4'hC, v); check("R7 holds when disabled", v, 32'hFF);
        feed(); rd(4'hC, v); check("R4 reload", v, 32'd10);
        rd(4'h0, v); check("R6 enable applied at feed", v, 32'h1);
        ticks(4); rd(4'hC, v); check("R7 decrement", v, 32'd6);

        // R3 set-only
        wr(4'h0, 32'h0); feed(); rd(4'h0, v); check("R3 zero write keeps enable", v, 32'h1);
        wr(4'h0, 32'h2); rd(4'h0, v); check("R6 rsten pending", v, 32'h1);
        feed(); rd(4'h0, v); check("R6 rsten applied", v, 32'h3);

        // R5 aborted feeds
        ticks(3); rd(4'hC, v); check("R7 count before abort", v, 32'd7);
        wr(4'h8, 32'hAA); rd(4'hC, v); wr(4'h8, 32'h55);
        rd(4'hC, v); check("R5 interleaved access aborts", v, 32'd7);
        wr(4'h8, 32'hAA); wr(4'h8, 32'h56);
        rd(4'hC, v); check("R5 wrong byte aborts", v, 32'd7);
        wr(4'h8, 32'hAA); wr(4'h0, 32'h4); wr(4'h8, 32'h55);
        rd(4'hC, v); check("R5 mode write aborts", v, 32'd7);

        // R7 random tick patterns, no underflow
        for (int it = 0; it < 40; it++) begin
            tcv = 32'(1 + ($urandom % 15));
            wr(4'h4, tcv);
            feed();
            nt = 0;
            for (int c = 0; c < int'($urandom % 12); c++) begin
                logic t;
                t = 1'($urandom % 2);
                if (nt + int'(t) > int'(tcv)) t = 1'b0;
                tick = t;
                cyc();
                nt += int'(t);
            end
            tick = 1'b0;
            rd(4'hC, v); check("R7 random ticks", v, exp_count(tcv, nt));
        end

        // R8 interrupt time-out
        pulse_por();
        wr(4'h4, 32'd3); wr(4'h0, 32'h1); feed();
        tick = 1'b1;
        for (int c = 0; c < 4; c++) begin
            check("R8 no early irq", {31'b0, irq}, 0);
            cyc();
        end
        tick = 1'b0;
        check("R8 irq raised", {31'b0, irq}, 1);
        check("R8 no reset request", {31'b0, rreq}, 0);
        rd(4'h0, v); check("R8 flags after interrupt time-out", v, 32'hC);
        ticks(2); rd(4'hC, v); check("R8 counter stopped", v, 0);

        // R9 flag clearing
        wr(4'h0, 32'h0); rd(4'h0, v); check("R9 tof cleared, intf kept", v, 32'h8);
        wr(4'h0, 32'h4); rd(4'h0, v); check("R9 writing 1 does not set tof", v, 32'h8);
        check("R9 irq stays", {31'b0, irq}, 1);

        // R8 reset time-out, R10 resets
        pulse_por();
        check("R10 por clears irq", {31'b0, irq}, 0);
        wr(4'h4, 32'd2); wr(4'h0, 32'h3); feed();
        rd(4'h0, v); check("R6 both bits applied", v, 32'h3);
        tick = 1'b1;
        cyc(); cyc();
        check("R8 no request before underflow", {31'b0, rreq}, 0);
        cyc();
        tick = 1'b0;
        check("R8 reset request high", {31'b0, rreq}, 1);
        check("R8 no irq with reset-enable", {31'b0, irq}, 0);
        cyc();
        check("R8 reset request one cycle", {31'b0, rreq}, 0);
        rd(4'h0, v); check("R8 flags after reset time-out", v, 32'h4);
        rst_sys = 1'b1; cyc(); rst_sys = 1'b0;
        rd(4'h0, v); check("R10 sys reset keeps tof", v, 32'h4);
        rd(4'h4, v); check("R10 sys reset tc", v, 32'hFF);
        rd(4'hC, v); check("R10 sys reset value", v, 32'hFF);
        pulse_por();
        rd(4'h0, v); check("R10 por clears tof", v, 0);

        summary();
        $finish;
    end

endmodule